// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds four 64-bit performance counters for a cache controller. Each counter is told by a small event code which one of a vector of single-cycle event strobes it should count: cycles, instruction or data hits and misses, victim hits, tag probes, request types and the like. The strobes are produced elsewhere and arrive as one input vector indexed by event code. Code 0 needs no strobe at all; it counts every clock.

A configuration write sets one counter's event code and its clear-on-read flag together. Such a write never disturbs the accumulated count, so software can retarget a counter while it runs. A read names one counter and returns its 64-bit value one cycle later; if that counter has clear-on-read enabled, the read also restarts it, and an event landing in the very cycle of the read is kept by restarting at 1.

Top module: `perf_counter_bank`

## Requirements
- R1: A synchronous reset sets every count to 0, every event code to 0 and every clear-on-read flag to 0, and drops `rd_valid`.
- R2: A counter whose event code is 0 adds 1 in every clock cycle out of reset; bit 0 of the strobe space needs no input.
- R3: A counter whose event code c lies in 1..NUM_EVT-1 adds 1 in exactly those cycles where `evt_i[c]` is 1 (for example code 3 is data miss, code 7 is victim hit).
- R4: A counter whose event code is NUM_EVT or greater (54..63 by default) never changes except through clear-on-read.
- R5: `rd_en` high in cycle t with `rd_sel` = k makes `rd_valid` high in cycle t+1 with `rd_data` equal to counter k's value as it stood during cycle t; `rd_en` low makes `rd_valid` low in the next cycle.
- R6: A read of a counter whose clear-on-read flag is 1 leaves that counter at 0 after the read edge when its event is idle in that cycle.
- R7: When a clear-on-read coincides with that counter's event strobe, the counter is left at 1.
- R8: A read of a counter whose clear-on-read flag is 0 does not alter its count.
- R9: A configuration write (`cfg_we`, `cfg_sel`, `cfg_code`, `cfg_clr_on_rd`) leaves the target count unchanged; the new code governs counting from the cycle after the write.
- R10: The four counters, selected by a 2-bit index 0..3, count, clear and are configured independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_EVT-1 | Event strobes; bit c (1..NUM_EVT-1) is event code c |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Counter targeted by the write |
| cfg_code | input | 6 | New event code |
| cfg_clr_on_rd | input | 1 | New clear-on-read flag |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Counter to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 64 | Count returned by the read |

## Verification
The two functions that can land in one cycle are a clear-on-read and the counter's own increment, and separately a configuration write and counting on the old code. The bench provokes the first by holding the victim-hit strobe high while reading a clear-on-read counter twice back to back, so the second read must return 1, and also fires random reads under random strobe patterns; the second by rewriting a counter's code in the middle of random traffic and reading it afterwards. Every returned value is compared with a requirement-level model whose expected items are queued at the read edge and popped when `rd_valid` shows.

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_CTR = 4,
  parameter int NUM_EVT = 54,
  parameter int CODE_W  = 6,
  parameter int CNT_W   = 64,
  localparam int SEL_W  = $clog2(NUM_CTR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:1] evt_i,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [CODE_W-1:0]  cfg_code,
  input  logic               cfg_clr_on_rd,
  input  logic               rd_en,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic               rd_valid,
  output logic [CNT_W-1:0]   rd_data
);
  localparam int SPACE = 2 ** CODE_W;
  localparam int PAD   = SPACE - NUM_EVT;

  logic [CNT_W-1:0]  cnt  [NUM_CTR];
  logic [CODE_W-1:0] code [NUM_CTR];
  logic [NUM_CTR-1:0] cor;
  logic [NUM_CTR-1:0] hit;
  logic [SPACE-1:0]   strobes;

  // code 0 is the cycle count; codes past the implemented range read as 0
  assign strobes = {{PAD{1'b0}}, evt_i, 1'b1};

  always_comb
    for (int i = 0; i < NUM_CTR; i++) hit[i] = strobes[code[i]];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      cor      <= '0;
      for (int i = 0; i < NUM_CTR; i++) begin
        cnt[i]  <= '0;
        code[i] <= '0;
      end
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= cnt[rd_sel];
      for (int i = 0; i < NUM_CTR; i++) begin
        if (rd_en && rd_sel == SEL_W'(i) && cor[i])
          cnt[i] <= CNT_W'(hit[i]);
        else
          cnt[i] <= cnt[i] + CNT_W'(hit[i]);
        if (cfg_we && cfg_sel == SEL_W'(i)) begin
          code[i] <= cfg_code;
          cor[i]  <= cfg_clr_on_rd;
        end
      end
    end
  end
endmodule

module perf_counter_bank_chk #(
  parameter int NUM_CTR = 4,
  parameter int CODE_W  = 6,
  parameter int CNT_W   = 64,
  localparam int SEL_W  = $clog2(NUM_CTR)
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_en,
  input logic [SEL_W-1:0]   rd_sel,
  input logic               rd_valid,
  input logic [CNT_W-1:0]   cnt  [NUM_CTR],
  input logic [CODE_W-1:0]  code [NUM_CTR],
  input logic [NUM_CTR-1:0] cor
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk)
    if (rst_q && !rst)
      for (int i = 0; i < NUM_CTR; i++)
        assert_reset_state_R1: assert (cnt[i] == '0 && code[i] == '0 && !cor[i]);

  assert_valid_follows_rd_R5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_no_valid_without_rd_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    assert_clear_leaves_le1_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_sel == SEL_W'(g) && cor[g]) |=> cnt[g] <= CNT_W'(1));
    assert_step_at_most_one_R8: assert property (@(posedge clk) disable iff (rst)
      !(rd_en && rd_sel == SEL_W'(g) && cor[g]) |=> (cnt[g] - $past(cnt[g])) <= CNT_W'(1));
  end
endmodule

bind perf_counter_bank perf_counter_bank_chk #(
  .NUM_CTR(NUM_CTR), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel), .rd_valid(rd_valid),
  .cnt(cnt), .code(code), .cor(cor)
);

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb;
  localparam int NE = 54;

  logic        clk = 0;
  logic        rst = 1;
  logic [NE-1:1] evt = '0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [5:0]  cfg_code = 0;
  logic        cfg_cor = 0;
  logic        rd_en = 0;
  logic [1:0]  rd_sel = 0;
  logic        rd_valid;
  logic [63:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R1";

  logic [63:0] mcnt [4];
  logic [5:0]  mcode [4];
  logic        mcor [4];
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  perf_counter_bank u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_code(cfg_code), .cfg_clr_on_rd(cfg_cor), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // requirement model: queues the expected read item at the read edge, then advances
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin mcnt[i] = 0; mcode[i] = 0; mcor[i] = 0; end
    end else begin
      if (rd_en) begin exp_q.push_back(mcnt[rd_sel]); tag_q.push_back(cur_tag); end
      for (int i = 0; i < 4; i++) begin
        logic s;
        s = (mcode[i] == 0) ? 1'b1 : (mcode[i] < NE) ? evt[mcode[i]] : 1'b0;
        if (rd_en && rd_sel == 2'(i) && mcor[i]) mcnt[i] = {63'd0, s};
        else mcnt[i] = mcnt[i] + {63'd0, s};
      end
      if (cfg_we) begin mcode[cfg_sel] = cfg_code; mcor[cfg_sel] = cfg_cor; end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++; $display("FAIL R5 unexpected rd_valid actual=1 expected=0");
        end else begin
          logic [63:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (rd_data !== e) begin
            fails++; $display("FAIL %s rd_data actual=%0d expected=%0d", t, rd_data, e);
          end
        end
      end else if (exp_q.size() != 0) begin
        checks++; fails++;
        $display("FAIL R5 rd_valid actual=0 expected=1");
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [5:0] c, input logic f);
    cfg_we = 1; cfg_sel = sel; cfg_code = c; cfg_cor = f;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input string tag);
    cur_tag = tag; rd_en = 1; rd_sel = sel;
    @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin
      fails++; $display("FAIL R1 rd_valid in reset actual=%0b expected=0", rd_valid);
    end
    rst = 0;
    rd(2'd0, "R1");                          // first cycle out of reset: 0
    idle(2);
    checks++;
    if (rd_valid !== 1'b0) begin
      fails++; $display("FAIL R5 rd_valid idle actual=%0b expected=0", rd_valid);
    end
    rd(2'd1, "R2");                          // code 0 counts cycles
    rd(2'd1, "R2");
    rd(2'd1, "R8");                          // no clear without flag
    cfg(2'd1, 6'd3, 1'b0);                   // data miss
    rd(2'd1, "R9");                          // count kept across config write
    cfg(2'd2, 6'd60, 1'b0);                  // out of range
    cfg(2'd3, 6'd7, 1'b1);                   // victim hit, clear on read
    cfg(2'd0, 6'd5, 1'b1);
    rd(2'd2, "R4");
    for (int k = 0; k < 60; k++) begin
      evt = {$urandom, $urandom}[NE-1:1];
      if (k % 3 == 0) begin
        logic [1:0] s;
        s = 2'($urandom_range(0, 3));
        rd(s, s == 2 ? "R4" : s == 1 ? "R3" : s == 3 ? "R6" : "R10");
      end else idle(1);
    end
    evt = '0;
    rd(2'd3, "R6");
    rd(2'd3, "R6");                          // cleared, idle strobe: 0
    cfg(2'd1, 6'd6, 1'b0);                   // retarget mid-run
    for (int k = 0; k < 20; k++) begin
      evt = {$urandom, $urandom}[NE-1:1];
      idle(1);
    end
    rd(2'd1, "R9");
    evt = '0;
    evt[7] = 1'b1;
    rd(2'd3, "R7");
    rd(2'd3, "R7");                          // strobe held through clear: 1
    evt = '0;
    rd(2'd3, "R7");
    rd(2'd2, "R4");
    rd(2'd0, "R10");
    idle(3);
    rst = 1;
    idle(2);
    rst = 0;
    rd(2'd3, "R1");
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule